// File: doc/BRIEF.md
# One-Hot Bitmap Search Memory

This block is a content-addressable store of 32 words of 32 bits that needs no per-entry comparator. Every stored word is split into four byte lanes. Each lane owns a bitmap of 256 rows by 32 columns. Storing byte value `b` of entry `e` sets the single bit at row `b`, column `e`. A search uses each byte of the key as a row address and reads one 32-bit row from each lane. The four rows are ANDed, and the result is the match vector. It has one bit per entry, and the hit flag and the lowest matching index are derived from it.

Writes carry only a data word, and the block chooses the slot itself. A value that is already stored is refreshed in place. A new value takes the lowest empty slot. When every slot is in use, the new value replaces the lowest-index entry marked stale. Each entry has an age bit that hardware sets whenever the entry is written or refreshed. Software clears these bits through a mask port. A purge command then drops every entry that is still stale. A shadow copy of each stored word lets the block find the bitmap bits it must clear when an entry is overwritten or purged.

Top module: `onehot_cam`

## Requirements
- R1: One cycle after `srch_en`, `srch_valid` is high. `match_vec` then has bit e set exactly when entry e holds the key, `hit` is the OR of `match_vec`, and `hit_idx` is the lowest set bit.
- R2: A write of a value not stored, with a free slot present, takes the lowest free index. The next cycle shows `wr_ack`=1, `wr_status`=0 (new) and `wr_idx` set to that index.
- R3: A write of a value already stored allocates nothing. It reports `wr_status`=1 (refresh) with the index the value already occupies.
- R4: A write of a new value when every slot is occupied replaces the lowest-index stale entry and reports `wr_status`=2 (replace). After that, the old value of that slot no longer matches.
- R5: A write of a new value when every slot is occupied and fresh is refused with `wr_status`=3, and the stored contents stay unchanged.
- R6: `stale_en` with `stale_mask` marks entries stale. A write or refresh of an entry in the same cycle leaves that entry fresh.
- R7: `purge` deletes every occupied stale entry. Those values no longer match, and their indices are reused lowest first. A write presented in the purge cycle is refused with status 3.
- R8: A search in the same cycle as a write sees the contents before that write.
- R9: An entry matches only when all four byte lanes match. Bytes taken from different entries never produce a hit, and at most one bit of `match_vec` is set.
- R10: After reset, no entry is stored, `wr_ack` and `srch_valid` are low, and every search misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store or refresh `wr_data` |
| wr_data | input | 32 | Word to store |
| wr_ack | output | 1 | Write result valid (one cycle after `wr_en`) |
| wr_status | output | 2 | 0 new, 1 refresh, 2 replace, 3 refused |
| wr_idx | output | 5 | Entry used by the write |
| srch_en | input | 1 | Look up `srch_data` |
| srch_data | input | 32 | Search key |
| srch_valid | output | 1 | Search result valid |
| match_vec | output | 32 | One bit per matching entry |
| hit | output | 1 | Any entry matched |
| hit_idx | output | 5 | Lowest matching entry |
| stale_en | input | 1 | Apply `stale_mask` |
| stale_mask | input | 32 | Entries whose age bit is cleared |
| purge | input | 1 | Delete all occupied stale entries |

## Verification
A stale bitmap bit, left behind by a replaced or purged entry, shows up at the ports on the first search for that old value: `hit` is set where a miss is expected. A wrong shadow word does not show at the time of the write. It shows later, as a false hit after the entry's next replacement or purge. Age bits are visible only through allocation order: a wrong age bit appears at the next write that finds the store full, as the wrong replacement index or a wrong refusal. The sweep fills every slot and probes keys that mix bytes from neighbouring entries. It then drives the replacement, refusal, purge and same-cycle paths, so that each of these faults is exposed within a few cycles.

// File: rtl/cam_pkg.sv
package cam_pkg;
    localparam int CAM_ENTRIES = 32;
    localparam int CAM_WIDTH   = 32;
    localparam int LANE_BITS   = 8;
    localparam int LANE_ROWS   = 1 << LANE_BITS;

    typedef enum logic [1:0] {
        WR_NEW     = 2'd0,
        WR_REFRESH = 2'd1,
        WR_REPLACE = 2'd2,
        WR_REFUSED = 2'd3
    } wr_status_e;

    typedef struct packed {
        logic       ack;
        wr_status_e status;
    } wr_result_t;
endpackage

// File: rtl/cam_pick.sv
module cam_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/cam_lane.sv
module cam_lane
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                srch_en,
    input  logic [LANE_BITS-1:0]                srch_byte,
    output logic [ENTRIES-1:0]                  srch_row,
    input  logic [LANE_BITS-1:0]                look_byte,
    output logic [ENTRIES-1:0]                  look_row,
    input  logic                                set_en,
    input  logic [IW-1:0]                       set_idx,
    input  logic [LANE_BITS-1:0]                set_byte,
    input  logic [ENTRIES-1:0]                  clr_mask,
    input  logic [ENTRIES-1:0][LANE_BITS-1:0]   old_bytes
);
    // One row per byte value, one column per entry.
    logic [ENTRIES-1:0] bitmap [LANE_ROWS];

    assign look_row = bitmap[look_byte];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < LANE_ROWS; r++) bitmap[r] <= '0;
            srch_row <= '0;
        end else begin
            if (srch_en) srch_row <= bitmap[srch_byte];
            for (int e = 0; e < ENTRIES; e++) begin
                if (clr_mask[e]) bitmap[old_bytes[e]][e] <= 1'b0;
            end
            if (set_en) bitmap[set_byte][set_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/onehot_cam.sv
module onehot_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES = CAM_ENTRIES,
    parameter int WIDTH   = CAM_WIDTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    output logic                       wr_ack,
    output logic [1:0]                 wr_status,
    output logic [$clog2(ENTRIES)-1:0] wr_idx,
    input  logic                       srch_en,
    input  logic [WIDTH-1:0]           srch_data,
    output logic                       srch_valid,
    output logic [ENTRIES-1:0]         match_vec,
    output logic                       hit,
    output logic [$clog2(ENTRIES)-1:0] hit_idx,
    input  logic                       stale_en,
    input  logic [ENTRIES-1:0]         stale_mask,
    input  logic                       purge
);
    localparam int IW    = $clog2(ENTRIES);
    localparam int LANES = WIDTH / LANE_BITS;

    logic [ENTRIES-1:0]            valid_q, fresh_q;
    logic [WIDTH-1:0]              shadow_q [ENTRIES];
    logic [LANES-1:0][ENTRIES-1:0] srch_rows, look_rows;
    logic [ENTRIES-1:0]            look_vec, free_vec, stale_vec, clr_mask;
    logic                          look_any, free_any, stale_any, set_en, take;
    logic [IW-1:0]                 look_idx, free_idx, stale_idx, tgt;
    wr_status_e                    op;
    wr_result_t                    res_q;
    logic [IW-1:0]                 res_idx_q;
    logic                          srch_valid_q;

    // Byte lanes, each a one-hot bitmap.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ENTRIES-1:0][LANE_BITS-1:0] lane_old;
        always_comb begin
            for (int e = 0; e < ENTRIES; e++)
                lane_old[e] = shadow_q[e][l*LANE_BITS +: LANE_BITS];
        end
        cam_lane #(.ENTRIES(ENTRIES), .IW(IW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .srch_en   (srch_en),
            .srch_byte (srch_data[l*LANE_BITS +: LANE_BITS]),
            .srch_row  (srch_rows[l]),
            .look_byte (wr_data[l*LANE_BITS +: LANE_BITS]),
            .look_row  (look_rows[l]),
            .set_en    (set_en),
            .set_idx   (tgt),
            .set_byte  (wr_data[l*LANE_BITS +: LANE_BITS]),
            .clr_mask  (clr_mask),
            .old_bytes (lane_old)
        );
    end

    always_comb begin
        look_vec  = '1;
        match_vec = '1;
        for (int l = 0; l < LANES; l++) begin
            look_vec  &= look_rows[l];
            match_vec &= srch_rows[l];
        end
        if (!srch_valid_q) match_vec = '0;
        free_vec  = ~valid_q;
        stale_vec = valid_q & ~fresh_q;
    end

    cam_pick #(.N(ENTRIES), .IW(IW)) u_pick_look  (.vec(look_vec),  .found(look_any),  .idx(look_idx));
    cam_pick #(.N(ENTRIES), .IW(IW)) u_pick_free  (.vec(free_vec),  .found(free_any),  .idx(free_idx));
    cam_pick #(.N(ENTRIES), .IW(IW)) u_pick_stale (.vec(stale_vec), .found(stale_any), .idx(stale_idx));
    cam_pick #(.N(ENTRIES), .IW(IW)) u_pick_hit   (.vec(match_vec), .found(hit),       .idx(hit_idx));

    // Slot choice: refresh, then lowest free, then lowest stale.
    always_comb begin
        op       = WR_REFUSED;
        tgt      = '0;
        set_en   = 1'b0;
        clr_mask = '0;
        if (purge) begin
            clr_mask = stale_vec;
        end else if (wr_en) begin
            if (look_any) begin
                op  = WR_REFRESH;
                tgt = look_idx;
            end else if (free_any) begin
                op     = WR_NEW;
                tgt    = free_idx;
                set_en = 1'b1;
            end else if (stale_any) begin
                op       = WR_REPLACE;
                tgt      = stale_idx;
                set_en   = 1'b1;
                clr_mask = ENTRIES'(1) << stale_idx;
            end
        end
        take = wr_en && !purge && (op != WR_REFUSED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= '0;
            fresh_q      <= '0;
            res_q        <= '{ack: 1'b0, status: WR_NEW};
            res_idx_q    <= '0;
            srch_valid_q <= 1'b0;
            for (int e = 0; e < ENTRIES; e++) shadow_q[e] <= '0;
        end else begin
            logic [ENTRIES-1:0] fresh_n, valid_n;
            fresh_n = fresh_q & ~(stale_en ? stale_mask : '0);
            valid_n = valid_q;
            if (purge) valid_n = valid_q & ~stale_vec;
            if (take) begin
                valid_n[tgt] = 1'b1;
                fresh_n[tgt] = 1'b1;
            end
            valid_q <= valid_n;
            fresh_q <= fresh_n & valid_n;
            if (set_en) shadow_q[tgt] <= wr_data;
            res_q        <= '{ack: wr_en, status: op};
            res_idx_q    <= tgt;
            srch_valid_q <= srch_en;
        end
    end

    assign wr_ack     = res_q.ack;
    assign wr_status  = res_q.status;
    assign wr_idx     = res_idx_q;
    assign srch_valid = srch_valid_q;

    // Age bit never survives without an occupied slot.
    assert_fresh_in_use_R6: assert property (@(posedge clk) disable iff (rst)
        (fresh_q & ~valid_q) == '0);

    // Lane AND never leaves more than one candidate.
    assert_single_match_R9: assert property (@(posedge clk) disable iff (rst)
        srch_valid |-> $onehot0(match_vec));

    // Matches only come from slots occupied when the search was issued.
    assert_match_in_use_R1: assert property (@(posedge clk) disable iff (rst)
        srch_valid |-> ((match_vec & ~$past(valid_q)) == '0));

    assert_hit_idx_set_R1: assert property (@(posedge clk) disable iff (rst)
        (srch_valid && hit) |-> match_vec[hit_idx]);

    // A new allocation lands on a slot that was free.
    assert_new_on_free_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && wr_status == WR_NEW) |-> !(($past(valid_q) >> wr_idx) & ENTRIES'(1)));

    // Refusal outside a purge only when every slot was occupied and fresh.
    assert_refuse_full_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && wr_status == WR_REFUSED && !$past(purge)) |->
        (&$past(valid_q) && &$past(fresh_q)));
endmodule

// File: tb/tb_onehot_cam.sv
module tb_onehot_cam;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 0, srch_en = 0, stale_en = 0, purge = 0;
    logic [31:0] wr_data = '0, srch_data = '0, stale_mask = '0;
    logic        wr_ack, srch_valid, hit;
    logic [1:0]  wr_status;
    logic [4:0]  wr_idx, hit_idx;
    logic [31:0] match_vec;
    int          errors = 0, checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    onehot_cam dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_ack(wr_ack), .wr_status(wr_status), .wr_idx(wr_idx),
        .srch_en(srch_en), .srch_data(srch_data), .srch_valid(srch_valid),
        .match_vec(match_vec), .hit(hit), .hit_idx(hit_idx),
        .stale_en(stale_en), .stale_mask(stale_mask), .purge(purge)
    );

    function automatic logic [31:0] val(input int k);
        logic [7:0] b3, b2, b1;
        b3 = 8'(k + 16);
        b2 = 8'(k) ^ 8'hA5;
        b1 = 8'(k * 3);
        return {b3, b2, b1, 8'h5A};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic op(input logic w, input logic [31:0] wd, input logic s,
                      input logic [31:0] sd, input logic [31:0] sm, input logic p);
        @(negedge clk);
        wr_en = w; wr_data = wd; srch_en = s; srch_data = sd;
        stale_en = (sm != 0); stale_mask = sm; purge = p;
        @(posedge clk);
        #1;
        wr_en = 0; srch_en = 0; stale_en = 0; stale_mask = '0; purge = 0;
    endtask

    task automatic wr_chk(input logic [31:0] d, input logic [1:0] st, input int idx, input string req);
        op(1, d, 0, '0, '0, 0);
        chk(wr_ack && wr_status == st, req, {30'd0, wr_status}, {30'd0, st});
        if (st != 2'd3) chk(wr_idx == 5'(idx), req, {27'd0, wr_idx}, idx);
    endtask

    task automatic srch_chk(input logic [31:0] d, input bit exp_hit, input int idx, input string req);
        op(0, '0, 1, d, '0, 0);
        chk(srch_valid && hit == exp_hit, req, {31'd0, hit}, {31'd0, exp_hit});
        if (exp_hit) begin
            chk(match_vec == (32'd1 << idx), req, match_vec, 32'd1 << idx);
            chk(hit_idx == 5'(idx), req, {27'd0, hit_idx}, idx);
        end else begin
            chk(match_vec == '0, req, match_vec, '0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state
        #1;
        chk(!wr_ack && !srch_valid && !hit, "R10", {29'd0, wr_ack, srch_valid, hit}, 0);
        srch_chk(val(0), 0, 0, "R10");
        srch_chk(32'h0, 0, 0, "R10");

        // R2: fill every slot, lowest free index first
        for (int i = 0; i < 32; i++) wr_chk(val(i), 2'd0, i, "R2");
        // R1: each value found at its own slot
        for (int i = 0; i < 32; i++) srch_chk(val(i), 1, i, "R1");
        // R9: keys mixing bytes of two entries never hit
        for (int i = 0; i < 31; i++) begin
            logic [31:0] a, b;
            a = val(i); b = val(i + 1);
            srch_chk({a[31:24], b[23:0]}, 0, 0, "R9");
            srch_chk({b[31:8], a[7:0] ^ 8'h01}, 0, 0, "R9");
        end

        // R3: rewrite refreshes in place
        wr_chk(val(5), 2'd1, 5, "R3");
        srch_chk(val(5), 1, 5, "R3");

        // R5: full and all fresh -> refused, contents intact
        wr_chk(val(100), 2'd3, 0, "R5");
        srch_chk(val(100), 0, 0, "R5");
        srch_chk(val(0), 1, 0, "R5");

        // R6: stale clear and refresh of slot 0 in one cycle keeps it fresh
        op(1, val(0), 0, '0, 32'h1, 0);
        chk(wr_ack && wr_status == 2'd1 && wr_idx == 5'd0, "R6", {30'd0, wr_status}, 1);
        wr_chk(val(101), 2'd3, 0, "R6");

        // R4: slots 3 and 7 stale -> replaced lowest first
        op(0, '0, 0, '0, 32'h0000_0088, 0);
        wr_chk(val(102), 2'd2, 3, "R4");
        srch_chk(val(3), 0, 0, "R4");
        srch_chk(val(102), 1, 3, "R4");
        wr_chk(val(103), 2'd2, 7, "R4");
        srch_chk(val(7), 0, 0, "R4");
        wr_chk(val(104), 2'd3, 0, "R4");

        // R7: purge slots 10..12, write in purge cycle refused
        op(0, '0, 0, '0, 32'h0000_1C00, 0);
        op(1, val(105), 0, '0, '0, 1);
        chk(wr_ack && wr_status == 2'd3, "R7", {30'd0, wr_status}, 3);
        srch_chk(val(10), 0, 0, "R7");
        srch_chk(val(11), 0, 0, "R7");
        srch_chk(val(12), 0, 0, "R7");
        srch_chk(val(105), 0, 0, "R7");
        srch_chk(val(13), 1, 13, "R7");
        wr_chk(val(106), 2'd0, 10, "R7");
        wr_chk(val(107), 2'd0, 11, "R7");

        // R8: search and write of the same value in one cycle
        op(1, val(108), 1, val(108), '0, 0);
        chk(wr_ack && wr_status == 2'd0 && wr_idx == 5'd12, "R8", {27'd0, wr_idx}, 12);
        chk(srch_valid && !hit, "R8", {31'd0, hit}, 0);
        srch_chk(val(108), 1, 12, "R8");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule